// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the serial protocol engine of a small byte-addressed non-volatile store and its storage array. When a write transaction begins, the engine loads a 10-bit base address. Each data byte that follows is placed in a 16-entry page buffer at the slot given by the low four address bits. After each byte only those four bits advance, so the pointer wraps inside the page, and the six page bits never change during a transaction. A mask of written slots is kept alongside the data.

When the transaction ends with a stop, nothing has yet reached the array. The stop opens a self-timed write cycle. Busy rises at once. The filled slots are copied into the array one per clock, lowest slot first, and busy then stays high until a programmable clock count has elapsed. While busy is high the protocol engine must not acknowledge its address, and this block ignores every strobe.

The controller has four states. `ST_IDLE` waits for a load. A load moves it to `ST_FILL`. In `ST_FILL` a byte strobe fills one slot. A second load restarts the fill at a new base. A stop with an empty mask returns to `ST_IDLE`, and a stop with data moves to `ST_COMMIT`. `ST_COMMIT` writes one slot per clock and goes to `ST_HOLD` after it writes the last one. `ST_HOLD` returns to `ST_IDLE` when the cycle counter reaches zero.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy and mem_we are low and addr_ptr is zero.
- R2: The byte number i (counting from 0) of a transaction with base b goes to array address {b[9:4], (b[3:0]+i) mod 16}. The upper six address bits never change within a transaction.
- R3: When more than 16 bytes arrive before the stop, a later byte that lands on an occupied slot replaces the earlier one. Each slot reaches the array once, holding the newest value.
- R4: No array write occurs before the stop, and mem_we is never high while busy is low.
- R5: A stop that follows a load with no data byte leaves busy low, makes no array write and leaves addr_ptr at the base.
- R6: After a stop with data, the array writes begin in the clock cycle that follows the stop edge. They come one per clock, in strictly ascending slot order, and they cover exactly the slots that were written.
- R7: Busy rises in the cycle that follows the stop edge and stays high for exactly CYCLE_CLKS clock cycles (CYCLE_CLKS must be at least 17).
- R8: While busy is high, load, byte and stop strobes have no effect. They cause no extra writes, no change to addr_ptr and no new busy period.
- R9: After the commit, addr_ptr equals {b[9:4], (b[3:0]+n) mod 16}, where n is the number of bytes accepted.
- R10: A new load before the stop discards the bytes gathered so far. Only the bytes that follow it are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_load | input | 1 | Start of a write transaction: load the base address and clear the buffer |
| txn_addr | input | 10 | Base array address for the transaction |
| wr_stb | input | 1 | One received data byte |
| wr_data | input | 8 | Data byte that goes with wr_stb |
| stop_stb | input | 1 | Stop condition ending the transaction |
| busy | output | 1 | Self-timed write cycle in progress |
| mem_we | output | 1 | Array write enable, one byte per cycle |
| mem_addr | output | 10 | Array write address |
| mem_wdata | output | 8 | Array write data |
| addr_ptr | output | 10 | Shared address counter |

## Verification
The bench sweeps byte counts of 0, 1, 5, 15, 16, 17, 20 and 33 over base offsets at slot 0, mid-page and slot 15. With these it exercises wrap inside the page, overwrite and the empty transaction. A design that carried the increment into the page bits would write to the next page. A design that appended instead of overwriting would emit more than 16 writes or stale data. A design that committed on an empty stop would raise busy with nothing to write. Strobes injected during busy would show up as extra writes, a moved pointer or a second busy period. A restart before the stop would commit bytes from the abandoned base. Each of these faults shows at the ports.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } pgw_state_e;
endpackage

// File: rtl/pgw_slot_buf.sv
module pgw_slot_buf #(
    parameter int DATA_W    = 8,
    parameter int SLOT_BITS = 4,
    localparam int SLOTS    = 1 << SLOT_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [SLOT_BITS-1:0] wr_slot,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 drop_en,
    input  logic [SLOT_BITS-1:0] drop_slot,
    input  logic [SLOT_BITS-1:0] rd_slot,
    output logic [DATA_W-1:0]    rd_data,
    output logic [SLOTS-1:0]     mask
);
    logic [DATA_W-1:0] byte_q [SLOTS];
    logic [SLOTS-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (wr_en) byte_q[wr_slot] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else begin
            if (wr_en)   mask_q[wr_slot]   <= 1'b1;
            if (drop_en) mask_q[drop_slot] <= 1'b0;
        end
    end

    assign rd_data = byte_q[rd_slot];
    assign mask    = mask_q;
endmodule

// File: rtl/pgw_slot_scan.sv
module pgw_slot_scan #(
    parameter int SLOT_BITS = 4,
    localparam int SLOTS    = 1 << SLOT_BITS
) (
    input  logic [SLOTS-1:0]     mask,
    output logic [SLOT_BITS-1:0] low_slot,
    output logic                 any,
    output logic                 last
);
    always_comb begin
        low_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (mask[i]) low_slot = i[SLOT_BITS-1:0];
        end
    end

    assign any  = |mask;
    assign last = any && ((mask & (mask - 1'b1)) == '0);
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
    parameter int CYCLE_CLKS = 2_000_000,
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= CNT_W'(CYCLE_CLKS - 1);
        else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SLOT_BITS  = 4,
    parameter int CYCLE_CLKS = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_load,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stop_stb,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] addr_ptr
);
    import pgw_pkg::*;

    localparam int SLOTS = 1 << SLOT_BITS;

    pgw_state_e           state_q, state_d;
    logic [ADDR_W-1:0]    ptr_q;
    logic [SLOTS-1:0]     mask;
    logic [SLOT_BITS-1:0] low_slot;
    logic                 any_slot, last_slot;
    logic                 tmr_done;
    logic                 accept_load, accept_byte, start_cycle;
    logic [DATA_W-1:0]    rd_data;

    pgw_slot_buf #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept_load),
        .wr_en    (accept_byte),
        .wr_slot  (ptr_q[SLOT_BITS-1:0]),
        .wr_data  (wr_data),
        .drop_en  (mem_we),
        .drop_slot(low_slot),
        .rd_slot  (low_slot),
        .rd_data  (rd_data),
        .mask     (mask)
    );

    pgw_slot_scan #(.SLOT_BITS(SLOT_BITS)) u_scan (
        .mask    (mask),
        .low_slot(low_slot),
        .any     (any_slot),
        .last    (last_slot)
    );

    pgw_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start_cycle),
        .run  (busy),
        .done (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (txn_load) state_d = ST_FILL;
            ST_FILL: begin
                if (txn_load)      state_d = ST_FILL;
                else if (stop_stb) state_d = any_slot ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: if (last_slot) state_d = ST_HOLD;
            ST_HOLD:   if (tmr_done)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and strobe qualification
    always_comb begin
        busy        = 1'b0;
        mem_we      = 1'b0;
        accept_load = 1'b0;
        accept_byte = 1'b0;
        start_cycle = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept_load = txn_load;
            ST_FILL: begin
                accept_load = txn_load;
                accept_byte = wr_stb && !txn_load;
                start_cycle = stop_stb && !txn_load && any_slot;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                mem_we = any_slot;
            end
            ST_HOLD:   busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // shared address counter: page bits fixed, slot bits wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (accept_load) begin
            ptr_q <= txn_addr;
        end else if (accept_byte) begin
            ptr_q[SLOT_BITS-1:0] <= ptr_q[SLOT_BITS-1:0] + 1'b1;
        end
    end

    assign mem_addr  = {ptr_q[ADDR_W-1:SLOT_BITS], low_slot};
    assign mem_wdata = rd_data;
    assign addr_ptr  = ptr_q;
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
    parameter int ADDR_W     = 10,
    parameter int SLOT_BITS  = 4,
    parameter int CYCLE_CLKS = 2_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] addr_ptr
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    a_r4_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[SLOT_BITS-1:0] > $past(mem_addr[SLOT_BITS-1:0])));

    a_r6_first_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_we);

    a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:SLOT_BITS] == addr_ptr[ADDR_W-1:SLOT_BITS]));

    a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb));

    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(CYCLE_CLKS)));

    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_ptr));
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
    .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .addr_ptr(addr_ptr)
);

// File: tb/pgbuf_commit_bench.sv
`timescale 1ns/1ps
module pgbuf_commit_bench;
    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int CYC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_load = 1'b0;
    logic [AW-1:0] txn_addr = '0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          stop_stb = 1'b0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_addr, addr_ptr;
    logic [DW-1:0] mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW-1:0] log_a [4096];
    logic [DW-1:0] log_d [4096];
    int nlog = 0;

    always #2.5 clk = ~clk;

    pgbuf_commit #(.ADDR_W(AW), .DATA_W(DW), .SLOT_BITS(4), .CYCLE_CLKS(CYC)) u_pgbuf_commit (
        .clk(clk), .rst_n(rst_n), .txn_load(txn_load), .txn_addr(txn_addr),
        .wr_stb(wr_stb), .wr_data(wr_data), .stop_stb(stop_stb), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .addr_ptr(addr_ptr)
    );

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (nlog < 4096) begin
                log_a[nlog] = mem_addr;
                log_d[nlog] = mem_wdata;
            end
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dat(input logic [AW-1:0] b, input int i);
        return 8'(i * 37 + int'(b) + 11);
    endfunction

    function automatic logic [AW-1:0] ptr_exp(input logic [AW-1:0] b, input int n);
        return {b[AW-1:4], 4'(int'(b[3:0]) + n)};
    endfunction

    task automatic do_load(input logic [AW-1:0] b);
        @(negedge clk); txn_load = 1'b1; txn_addr = b;
        @(negedge clk); txn_load = 1'b0;
    endtask

    task automatic send_bytes(input logic [AW-1:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            wr_stb = 1'b1; wr_data = dat(b, i);
            @(negedge clk);
        end
        wr_stb = 1'b0;
    endtask

    task automatic do_stop();
        stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
        #1;
    endtask

    // compare the write log from mark onward with bytes dat(b,0..n-1)
    task automatic check_commit(input logic [AW-1:0] b, input int n, input int mark);
        logic [DW-1:0] ev [16];
        bit            vl [16];
        int            k, nexp;
        for (int s = 0; s < 16; s++) begin vl[s] = 1'b0; ev[s] = '0; end
        for (int i = 0; i < n; i++) begin
            k = (int'(b[3:0]) + i) % 16;
            vl[k] = 1'b1;
            ev[k] = dat(b, i);
        end
        nexp = 0;
        for (int s = 0; s < 16; s++) if (vl[s]) nexp++;
        chk(nlog - mark == nexp, "R3 R6 write count", nlog - mark, nexp);
        k = mark;
        for (int s = 0; s < 16; s++) begin
            if (vl[s] && k < nlog) begin
                chk(log_a[k] == {b[AW-1:4], 4'(s)}, "R2 R6 address", int'(log_a[k]), int'({b[AW-1:4], 4'(s)}));
                chk(log_d[k] == ev[s], "R3 data", int'(log_d[k]), int'(ev[s]));
                k++;
            end
        end
        chk(addr_ptr == ptr_exp(b, n), "R9 pointer", int'(addr_ptr), int'(ptr_exp(b, n)));
    endtask

    task automatic run_txn(input logic [AW-1:0] b, input int n);
        int mark, blen;
        mark = nlog;
        do_load(b);
        send_bytes(b, n);
        #1;
        chk(nlog == mark && !busy, "R4 no write before stop", nlog - mark, 0);
        @(negedge clk);
        do_stop();
        if (n == 0) begin
            for (int c = 0; c < 5; c++) begin
                chk(!busy, "R5 no busy", int'(busy), 0);
                @(negedge clk); #1;
            end
            chk(nlog == mark, "R5 no write", nlog - mark, 0);
            chk(addr_ptr == b, "R5 pointer", int'(addr_ptr), int'(b));
        end else begin
            blen = 0;
            while (busy && blen < 1000) begin
                blen++;
                @(negedge clk); #1;
            end
            chk(blen == CYC, "R7 busy length", blen, CYC);
            check_commit(b, n, mark);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] bases [4];
        int            cnts  [8];
        int            mark;
        bases[0] = 10'h000; bases[1] = 10'h3F5; bases[2] = 10'h12C; bases[3] = 10'h0BF;
        cnts[0] = 0; cnts[1] = 1; cnts[2] = 5; cnts[3] = 15;
        cnts[4] = 16; cnts[5] = 17; cnts[6] = 20; cnts[7] = 33;

        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_we && addr_ptr == '0, "R1 reset", int'({busy, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !mem_we && addr_ptr == '0, "R1 after release", int'(addr_ptr), 0);

        for (int bi = 0; bi < 4; bi++)
            for (int ci = 0; ci < 8; ci++)
                run_txn(bases[bi], cnts[ci]);

        // R10: restart before stop abandons earlier bytes
        mark = nlog;
        do_load(10'h0F0);
        send_bytes(10'h0F0, 3);
        do_load(10'h30E);
        send_bytes(10'h30E, 2);
        @(negedge clk);
        do_stop();
        while (busy) begin @(negedge clk); #1; end
        check_commit(10'h30E, 2, mark);
        chk(nlog - mark == 2, "R10 only new bytes", nlog - mark, 2);

        // R8: strobes during busy are ignored
        mark = nlog;
        do_load(10'h2A7);
        send_bytes(10'h2A7, 3);
        @(negedge clk);
        do_stop();
        repeat (3) @(negedge clk);
        txn_load = 1'b1; txn_addr = 10'h155; wr_stb = 1'b1; wr_data = 8'hEE; stop_stb = 1'b1;
        @(negedge clk);
        txn_load = 1'b0; wr_stb = 1'b0; stop_stb = 1'b0;
        @(negedge clk);
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
        #1;
        while (busy) begin @(negedge clk); #1; end
        check_commit(10'h2A7, 3, mark);
        chk(addr_ptr == 10'h2AA, "R8 pointer unchanged", int'(addr_ptr), 10'h2AA);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); #1;
            chk(!busy, "R8 no new busy", int'(busy), 0);
        end
        chk(nlog - mark == 3, "R8 no extra writes", nlog - mark, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule